// File: doc/BRIEF.md
# Burst alias register window

This block is the register-file front end of a peripheral. It holds a small bank of 16-bit registers behind a simple synchronous bus. It also provides one fixed alias address, through which a DMA engine can move a whole run of consecutive registers without changing its own address. A configuration register holds two values. The first is a base slot, counted in 32-bit register slots from the first bank register. The second is a transfer count, stored as the count minus one.

Every read or write of the alias address goes to the bank register at slot `base + index`, which is byte address `(base + index) * 4`. A hidden index then advances. After the access that used the last index of the programmed burst, the index returns to zero, so the next alias access starts a new burst at the base. Writing the configuration register restarts the index. An access that lands beyond the last bank register reads as zero and changes nothing, but it still uses up its place in the burst.

Top module: `burst_alias_regfile`

## Requirements
- R1: After reset the configuration register reads 0, every bank register reads 0, and the first alias access targets the base slot.
- R2: The configuration register is at byte address 0x48. Its bits 12:8 hold the count field and its bits 4:0 hold the base field, and both read back as written. Bits 15:13 and 7:5 always read as 0.
- R3: Bank register n, for n from 0 to 17, is read and written directly at byte address 4*n, and the two low address bits are ignored. Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. Direct reads of unmapped addresses return 0.
- R4: A read or write at the alias address 0x4C reaches bank slot `base + index`, and all 16 data bits are carried both ways.
- R5: Each alias access advances the index by one. After the access whose index equals the effective count field, the index returns to 0, so a burst is count+1 accesses long.
- R6: Direct accesses to bank registers or unmapped addresses, and reads of the configuration register, leave the index unchanged.
- R7: A write to the configuration register sets the index to 0.
- R8: An alias access whose slot `base + index` is 18 or higher reads as 0 and writes nothing, and the index still advances.
- R9: A count field above 17 is treated as 17, so a burst is at most 18 accesses long. The field still reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_re | input | 1 | Read strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered, valid in the cycle after `bus_re` |

## Verification
The assertions check these rules on every cycle: the index never goes above the clamp, it advances by exactly one on an alias access below the burst end, it wraps to zero at the burst end, it is cleared by a configuration write, and it does not move for any other access. They also check that reserved configuration bits and out-of-range alias reads return zero, and that read data holds between reads. Only the bench scenarios can show that the data lands in the right slot. This covers data reaching the right register through the alias, ignored out-of-range writes leaving the bank untouched, and full 18-transfer bursts with a clamped count, all compared against a bench model that runs random traffic.

// File: rtl/burst_alias_pkg.sv
package burst_alias_pkg;

  localparam int WORD_W        = 16;
  localparam int LEN_W         = 5;
  localparam int BASE_W        = 5;
  localparam int LEN_LSB       = 8;
  localparam int BASE_LSB      = 0;
  localparam int MAX_BURST_LEN = 17;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [BASE_W-1:0] base;
  } burst_cfg_t;

  // Place the configuration fields in a bus word; every other bit stays zero.
  function automatic logic [WORD_W-1:0] pack_cfg(burst_cfg_t cfg);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LEN_LSB  +: LEN_W]  = cfg.len;
    w[BASE_LSB +: BASE_W] = cfg.base;
    return w;
  endfunction

endpackage

// File: rtl/alias_addr_decode.sv
module alias_addr_decode #(
  parameter int SLOT_W     = 6,
  parameter int SEL_W      = 6,
  parameter int BASE_W     = 5,
  parameter int IDX_W      = 5,
  parameter int NUM_REGS   = 18,
  parameter int CTRL_SLOT  = 18,
  parameter int ALIAS_SLOT = 19
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [BASE_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic              we,
  input  logic              re,
  output logic              is_ctrl,
  output logic              is_alias,
  output logic [SEL_W-1:0]  sel,
  output logic              sel_hit,
  output logic              alias_step,
  output logic              ctrl_wr,
  output logic              bank_wr
);

  localparam logic [SLOT_W-1:0] CTRL_S  = SLOT_W'(CTRL_SLOT);
  localparam logic [SLOT_W-1:0] ALIAS_S = SLOT_W'(ALIAS_SLOT);
  localparam logic [SEL_W-1:0]  NREG_S  = SEL_W'(NUM_REGS);

  logic [SEL_W-1:0] tgt_sel;
  logic [SEL_W-1:0] direct_sel;

  always_comb begin
    is_ctrl    = (slot == CTRL_S);
    is_alias   = (slot == ALIAS_S);
    // Sum is formed at SEL_W bits, wide enough for base + idx with no wrap.
    tgt_sel    = SEL_W'(base) + SEL_W'(idx);
    direct_sel = SEL_W'(slot);
    sel        = is_alias ? tgt_sel : direct_sel;
    sel_hit    = !is_ctrl && (sel < NREG_S);
    alias_step = is_alias && (we || re);
    ctrl_wr    = is_ctrl && we;
    bank_wr    = we && sel_hit;
  end

endmodule

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_alias_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  burst_cfg_t wr_cfg,
  output burst_cfg_t cfg
);

  burst_cfg_t cfg_q;
  burst_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d = wr_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/burst_index_seq.sv
module burst_index_seq #(
  parameter int LEN_W   = 5,
  parameter int MAX_LEN = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] idx
);

  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  logic [LEN_W-1:0] idx_q;
  logic [LEN_W-1:0] idx_d;
  logic [LEN_W-1:0] len_eff;
  logic             last_beat;
  logic             idx_en;

  always_comb begin
    len_eff   = (len > MAX_L) ? MAX_L : len;
    last_beat = (idx_q >= len_eff);
    idx_en    = clear || step;
    if (clear) begin
      idx_d = '0;
    end else if (last_beat) begin
      idx_d = '0;
    end else begin
      idx_d = idx_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/burst_reg_bank.sv
module burst_reg_bank #(
  parameter int NUM_REGS = 18,
  parameter int DATA_W   = 16,
  parameter int SEL_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic              hit,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g);
    logic              en;
    logic [DATA_W-1:0] q;

    assign en = wr_en && (sel == MY_SEL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= wr_data;
      end
    end

    assign slot_q[g] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit && (sel == SEL_W'(i))) begin
        rd_data = slot_q[i];
      end
    end
  end

endmodule

// File: rtl/burst_alias_regfile.sv
module burst_alias_regfile
  import burst_alias_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_REGS   = 18,
  parameter int CTRL_ADDR  = 'h48,
  parameter int ALIAS_ADDR = 'h4C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);

  localparam int SLOT_W = ADDR_W - 2;
  localparam int SUM_W  = BASE_W + 1;
  localparam int SEL_W  = (SLOT_W > SUM_W) ? SLOT_W : SUM_W;

  // Reset: asserted at once, removed on the second clock edge after release.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  // The word slot comes from the upper address bits; the byte lane is ignored.
  logic unused_addr_lsb;
  assign unused_addr_lsb = ^bus_addr[1:0];

  burst_cfg_t       cfg;
  burst_cfg_t       wr_cfg;
  logic [LEN_W-1:0] burst_idx;
  logic             dec_is_ctrl;
  logic             dec_is_alias;
  logic [SEL_W-1:0] sel;
  logic             sel_hit;
  logic             alias_step;
  logic             ctrl_wr;
  logic             bank_wr;
  logic [WORD_W-1:0] bank_rd;
  logic [WORD_W-1:0] rd_d;
  logic [WORD_W-1:0] rd_q;

  alias_addr_decode #(
    .SLOT_W    (SLOT_W),
    .SEL_W     (SEL_W),
    .BASE_W    (BASE_W),
    .IDX_W     (LEN_W),
    .NUM_REGS  (NUM_REGS),
    .CTRL_SLOT (CTRL_ADDR / 4),
    .ALIAS_SLOT(ALIAS_ADDR / 4)
  ) u_decode (
    .slot      (bus_addr[ADDR_W-1:2]),
    .base      (cfg.base),
    .idx       (burst_idx),
    .we        (bus_we),
    .re        (bus_re),
    .is_ctrl   (dec_is_ctrl),
    .is_alias  (dec_is_alias),
    .sel       (sel),
    .sel_hit   (sel_hit),
    .alias_step(alias_step),
    .ctrl_wr   (ctrl_wr),
    .bank_wr   (bank_wr)
  );

  assign wr_cfg.len  = bus_wdata[LEN_LSB  +: LEN_W];
  assign wr_cfg.base = bus_wdata[BASE_LSB +: BASE_W];

  burst_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (ctrl_wr),
    .wr_cfg(wr_cfg),
    .cfg   (cfg)
  );

  burst_index_seq #(
    .LEN_W  (LEN_W),
    .MAX_LEN(MAX_BURST_LEN)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .step (alias_step),
    .clear(ctrl_wr),
    .len  (cfg.len),
    .idx  (burst_idx)
  );

  burst_reg_bank #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (WORD_W),
    .SEL_W   (SEL_W)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (bank_wr),
    .sel    (sel),
    .hit    (sel_hit),
    .wr_data(bus_wdata),
    .rd_data(bank_rd)
  );

  // Read return: configuration word, addressed bank slot, or zero.
  always_comb begin
    rd_d = dec_is_ctrl ? pack_cfg(cfg) : bank_rd;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q <= '0;
    end else if (bus_re) begin
      rd_q <= rd_d;
    end
  end

  assign bus_rdata = rd_q;

endmodule

// File: rtl/burst_alias_chk.sv
module burst_alias_chk #(
  parameter int LEN_W   = 5,
  parameter int MAX_LEN = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             we,
  input logic             re,
  input logic [15:0]      rdata,
  input logic             is_ctrl,
  input logic             is_alias,
  input logic             sel_hit,
  input logic [LEN_W-1:0] idx,
  input logic [LEN_W-1:0] len
);

  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  logic alias_acc;
  assign alias_acc = is_alias && (we || re);

  assert_idx_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= MAX_L);

  assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_acc && (idx < len) && (idx < MAX_L)) |=> (idx == $past(idx) + LEN_W'(1)));

  assert_idx_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_acc && ((idx >= len) || (idx == MAX_L))) |=> (idx == '0));

  assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!alias_acc && !(is_ctrl && we)) |=> $stable(idx));

  assert_ctrl_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctrl && we) |=> (idx == '0));

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctrl && re) |=> ((rdata[15:13] == 3'b000) && (rdata[7:5] == 3'b000)));

  assert_oob_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_alias && re && !sel_hit) |=> (rdata == 16'h0000));

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));

endmodule

bind burst_alias_regfile burst_alias_chk #(
  .LEN_W  (burst_alias_pkg::LEN_W),
  .MAX_LEN(burst_alias_pkg::MAX_BURST_LEN)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .we      (bus_we),
  .re      (bus_re),
  .rdata   (bus_rdata),
  .is_ctrl (dec_is_ctrl),
  .is_alias(dec_is_alias),
  .sel_hit (sel_hit),
  .idx     (burst_idx),
  .len     (cfg.len)
);

// File: tb/burst_alias_regfile_bench.sv
`timescale 1ns/1ps
module burst_alias_regfile_bench;

  localparam int NREG = 18;
  localparam logic [7:0] A_CFG   = 8'h48;
  localparam logic [7:0] A_ALIAS = 8'h4C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic        bus_re;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  burst_alias_regfile u_burst_alias_regfile (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  // Reference model built from the requirements
  logic [15:0] m_bank [NREG];
  int m_len, m_base, m_idx;

  function automatic int eff_len(int l);
    return (l > 17) ? 17 : l;
  endfunction

  task automatic model_access(input logic [7:0] a, input bit wr,
                              input logic [15:0] d, output logic [15:0] exp);
    int slot;
    int t;
    slot = int'(a) >> 2;
    exp  = 16'h0000;
    if (slot < NREG) begin
      if (wr) m_bank[slot] = d; else exp = m_bank[slot];
    end else if (slot == 18) begin
      if (wr) begin
        m_len  = int'(d[12:8]);
        m_base = int'(d[4:0]);
        m_idx  = 0;
      end else begin
        exp = {3'b000, m_len[4:0], 3'b000, m_base[4:0]};
      end
    end else if (slot == 19) begin
      t = m_base + m_idx;
      if (t < NREG) begin
        if (wr) m_bank[t] = d; else exp = m_bank[t];
      end
      m_idx = (m_idx >= eff_len(m_len)) ? 0 : m_idx + 1;
    end
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_rd(input logic [7:0] a, input string tag);
    logic [15:0] exp;
    @(negedge clk);
    bus_addr = a;
    bus_re   = 1'b1;
    model_access(a, 1'b0, 16'h0000, exp);
    @(negedge clk);
    bus_re = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [15:0] d);
    logic [15:0] unused_exp;
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    model_access(a, 1'b1, d, unused_exp);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic set_cfg(input int len, input int base);
    logic [15:0] w;
    w = 16'h0000;
    w[12:8] = len[4:0];
    w[4:0]  = base[4:0];
    do_wr(A_CFG, w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1B2C3D4E));
    for (int i = 0; i < NREG; i++) m_bank[i] = 16'h0000;
    m_len = 0; m_base = 0; m_idx = 0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_re = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 rdata after reset", bus_rdata, 16'h0000);
    do_rd(A_CFG, "R1 cfg reset");
    for (int i = 0; i < NREG; i++) do_rd(8'(i * 4), "R1 bank reset");
    do_rd(A_ALIAS, "R1 first alias");

    // R2: field layout and reserved bits
    do_wr(A_CFG, 16'hFFFF);
    do_rd(A_CFG, "R2 cfg all ones");
    do_wr(A_CFG, 16'h0A15);
    do_rd(A_CFG, "R2 cfg pattern");

    // R3: direct bank access, byte lane bits ignored
    for (int i = 0; i < NREG; i++) do_wr(8'(i * 4 + (i % 4)), 16'(i * 16'h0911 ^ 16'hA5C3));
    for (int i = 0; i < NREG; i++) do_rd(8'(i * 4 + ((i + 1) % 4)), "R3 direct readback");
    do_rd(8'h50, "R3 unmapped read");
    do_rd(8'hFC, "R3 unmapped read high");

    // R4 R5: burst of 4 from slot 2, then wrap back to slot 2
    set_cfg(3, 2);
    for (int i = 0; i < 5; i++) do_rd(A_ALIAS, "R4 R5 burst read and wrap");

    // R6: direct traffic does not move the index
    set_cfg(4, 0);
    do_rd(A_ALIAS, "R6 alias idx0");
    do_rd(8'h1C, "R6 direct read");
    do_wr(8'h24, 16'h5A5A);
    do_rd(A_CFG, "R6 cfg read");
    do_wr(8'h80, 16'h1234);
    do_rd(A_ALIAS, "R6 alias idx1");

    // R7: configuration write restarts the burst
    do_rd(A_ALIAS, "R7 alias idx2");
    set_cfg(4, 0);
    do_rd(A_ALIAS, "R7 alias after restart");

    // R8: run past the end of the bank
    set_cfg(3, 16);
    for (int i = 0; i < 5; i++) do_rd(A_ALIAS, "R8 oob read");
    set_cfg(3, 16);
    do_wr(A_ALIAS, 16'hBEEF);
    do_wr(A_ALIAS, 16'hCAFE);
    do_wr(A_ALIAS, 16'hDEAD);
    do_wr(A_ALIAS, 16'hF00D);
    do_rd(A_ALIAS, "R8 wrap after oob writes");
    do_rd(8'h40, "R8 slot16 direct");
    do_rd(8'h44, "R8 slot17 direct");
    do_rd(8'h00, "R8 slot0 untouched");
    set_cfg(31, 31);
    do_wr(A_ALIAS, 16'h7777);
    for (int i = 0; i < NREG; i++) do_rd(8'(i * 4), "R8 bank unchanged");

    // R9 R4: clamped count gives 18 transfers through the alias
    set_cfg(25, 0);
    for (int i = 0; i < NREG; i++) do_wr(A_ALIAS, 16'($urandom));
    for (int i = 0; i < NREG; i++) do_rd(8'(i * 4), "R9 R4 full burst write");
    for (int i = 0; i < NREG + 1; i++) do_rd(A_ALIAS, "R9 clamped burst read");
    do_rd(A_CFG, "R9 count reads as written");
    set_cfg(17, 0);
    for (int i = 0; i < NREG + 1; i++) do_rd(A_ALIAS, "R9 count 17 read");

    // Random mix
    for (int n = 0; n < 700; n++) begin
      int r;
      r = int'($urandom % 8);
      case (r)
        0, 1, 2: do_rd(A_ALIAS, "R4 R5 random alias read");
        3:       do_wr(A_ALIAS, 16'($urandom));
        4:       do_rd(8'($urandom), "R3 R6 random direct read");
        5:       do_wr(8'(($urandom % NREG) * 4 + ($urandom % 4)), 16'($urandom));
        6:       do_wr(A_CFG, 16'($urandom));
        default: do_rd(A_CFG, "R2 random cfg read");
      endcase
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule